// File: doc/BRIEF.md
# ISP JTAG Test Access Port

This block is the serial test and programming port of an in-system-programmable logic device. It contains the sixteen-state test access port controller, a four-bit instruction register, a one-bit bypass stage, a 32-bit identification register and a shift register that carries a row address and a row of configuration data. Data and mode inputs are sampled on the rising edge of the test clock. The serial output changes on the falling edge and is enabled only while a register is being shifted.

A small instruction set drives an external configuration memory. Programming starts with an enable instruction. After it, the erase, program and verify instructions each raise a one-cycle strobe toward the memory. Program writes the data field into the row named by the address field. Verify reads that row back into the data field so it can be shifted out and compared. Erase clears the whole array. Without an earlier enable, these three instructions do nothing. The port has no test-reset pin. A power-on reset or five clocks with the mode input held high return the controller to its reset state.

Top module: `isp_tap`

## Requirements
- R1: The controller follows the standard sixteen-state TAP transition graph on rising TCK edges. An active-low `por_n` forces Test-Logic-Reset asynchronously. Five rising edges with `tms` high reach Test-Logic-Reset from any state, and with `tms` held high it stays there.
- R2: The instruction register is 4 bits wide and is shifted LSB first. Capture-IR loads 0001. Test-Logic-Reset makes the identification instruction (0001) current.
- R3: Instruction 0001 places the 32-bit identification register, loaded from parameter `IDCODE` at Capture-DR, between `tdi` and `tdo`, LSB first.
- R4: Instruction 1111, and every code that is not otherwise defined, selects a one-bit bypass stage that captures 0. The serial output is then the input delayed by one bit.
- R5: Codes 1001 (enable), 1010 (erase), 1011 (program) and 1100 (verify) select a 12-bit programming shift register. Bits [11:8] hold the row address and bits [7:0] hold the row data. `tdi` enters at bit 11 and bit 0 leaves first. Capture-DR leaves its contents unchanged.
- R6: Making 1001 the current instruction turns the programming enable on. Only Test-Logic-Reset turns it off.
- R7: While the enable is off, `cfg_erase`, `cfg_prog` and `cfg_verify` stay low, and the configuration memory is left untouched.
- R8: With the enable on, a strobe is high for exactly one TCK cycle, in the first Run-Test/Idle cycle entered directly from an update state. Erase fires after Update-IR or Update-DR. Program and verify fire only after Update-DR. `cfg_row` is the address field and `cfg_wdata` is the data field.
- R9: At the end of the verify strobe cycle, the data field loads `cfg_rdata` and the address field is kept.
- R10: `tdo` changes only on falling TCK edges. `tdo_oe` is high only during the Shift-IR and Shift-DR states and is low during reset.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for the tdo driver |
| cfg_erase | output | 1 | Whole-array erase strobe |
| cfg_prog | output | 1 | Row write strobe |
| cfg_verify | output | 1 | Row read strobe |
| cfg_row | output | ROW_AW | Row address |
| cfg_wdata | output | ROW_DW | Row data to write |
| cfg_rdata | input | ROW_DW | Row data read back, combinational from cfg_row |

## Verification
Each data register is shifted with distinct bit patterns. The identification readout shows that the reset instruction is correct. Bypass with an alternating pattern, tried under both 1111 and an undefined code, separates a one-bit delay from a pass-through or a wrong capture value. Programming two rows with different data and then verifying one of them, before and after an erase, ties address routing, write data and readback to the right bit fields. The same program sequence is repeated with no enable and again after a mode-line reset, which shows the strobes are gated. Dwelling several cycles in Run-Test/Idle shows that each strobe fires once.

// File: rtl/isp_tap_pkg.sv
package isp_tap_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,
        TAP_IDLE,
        DR_SELECT,
        DR_CAPTURE,
        DR_SHIFT,
        DR_EXIT1,
        DR_PAUSE,
        DR_EXIT2,
        DR_UPDATE,
        IR_SELECT,
        IR_CAPTURE,
        IR_SHIFT,
        IR_EXIT1,
        IR_PAUSE,
        IR_EXIT2,
        IR_UPDATE
    } tap_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] OP_ENABLE = 4'b1001;
    localparam logic [IR_W-1:0] OP_ERASE  = 4'b1010;
    localparam logic [IR_W-1:0] OP_PROG   = 4'b1011;
    localparam logic [IR_W-1:0] OP_VERIFY = 4'b1100;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_ID,
        SEL_ISP
    } dr_sel_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            TAP_RESET:  n = tms ? TAP_RESET : TAP_IDLE;
            TAP_IDLE:   n = tms ? DR_SELECT : TAP_IDLE;
            DR_SELECT:  n = tms ? IR_SELECT : DR_CAPTURE;
            DR_CAPTURE: n = tms ? DR_EXIT1  : DR_SHIFT;
            DR_SHIFT:   n = tms ? DR_EXIT1  : DR_SHIFT;
            DR_EXIT1:   n = tms ? DR_UPDATE : DR_PAUSE;
            DR_PAUSE:   n = tms ? DR_EXIT2  : DR_PAUSE;
            DR_EXIT2:   n = tms ? DR_UPDATE : DR_SHIFT;
            DR_UPDATE:  n = tms ? DR_SELECT : TAP_IDLE;
            IR_SELECT:  n = tms ? TAP_RESET : IR_CAPTURE;
            IR_CAPTURE: n = tms ? IR_EXIT1  : IR_SHIFT;
            IR_SHIFT:   n = tms ? IR_EXIT1  : IR_SHIFT;
            IR_EXIT1:   n = tms ? IR_UPDATE : IR_PAUSE;
            IR_PAUSE:   n = tms ? IR_EXIT2  : IR_PAUSE;
            IR_EXIT2:   n = tms ? IR_UPDATE : IR_SHIFT;
            IR_UPDATE:  n = tms ? DR_SELECT : TAP_IDLE;
            default:    n = TAP_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
        dr_sel_e s;
        case (op)
            OP_IDCODE: s = SEL_ID;
            OP_ENABLE,
            OP_ERASE,
            OP_PROG,
            OP_VERIFY: s = SEL_ISP;
            default:   s = SEL_BYPASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/isp_tap_fsm.sv
module isp_tap_fsm
    import isp_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.st <= TAP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

endmodule

// File: rtl/isp_tap_ir.sv
module isp_tap_ir
    import isp_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_so
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] cur;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            TAP_RESET:  r_d.cur = OP_IDCODE;
            IR_CAPTURE: r_d.sh  = OP_IDCODE;
            IR_SHIFT:   r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            IR_UPDATE:  r_d.cur = r_q.sh;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.sh  <= '0;
            r_q.cur <= OP_IDCODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ir    = r_q.cur;
    assign ir_so = r_q.sh[0];

endmodule

// File: rtl/isp_tap_dr.sv
module isp_tap_dr
    import isp_tap_pkg::*;
#(
    parameter int          ID_W   = 32,
    parameter logic [31:0] IDCODE = 32'h1C3A_5E2F
) (
    input  logic       tck,
    input  logic       por_n,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    input  logic       tdi,
    output logic       byp_so,
    output logic       id_so
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == DR_CAPTURE) begin
            if (sel == SEL_BYPASS) r_d.byp = 1'b0;
            if (sel == SEL_ID)     r_d.id  = IDCODE[ID_W-1:0];
        end else if (state == DR_SHIFT) begin
            if (sel == SEL_BYPASS) r_d.byp = tdi;
            if (sel == SEL_ID)     r_d.id  = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.byp <= 1'b0;
            r_q.id  <= IDCODE[ID_W-1:0];
        end else begin
            r_q <= r_d;
        end
    end

    assign byp_so = r_q.byp;
    assign id_so  = r_q.id[0];

endmodule

// File: rtl/isp_tap_isp.sv
module isp_tap_isp
    import isp_tap_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir,
    input  logic            tdi,
    input  logic [DW-1:0]   row_rdata,
    output logic            sr_so,
    output logic            en,
    output logic            erase,
    output logic            prog,
    output logic            verify,
    output logic [AW-1:0]   row,
    output logic [DW-1:0]   wdata
);

    localparam int SW = AW + DW;

    typedef struct packed {
        logic [SW-1:0] sr;
        logic          en;
        logic          arm_ir;
        logic          arm_dr;
    } isp_regs_t;

    isp_regs_t r_d, r_q;

    logic sel_isp;
    logic in_idle;

    always_comb begin
        sel_isp = (dr_select(ir) == SEL_ISP);
        in_idle = (state == TAP_IDLE) && r_q.en;

        erase  = in_idle && (r_q.arm_ir || r_q.arm_dr) && (ir == OP_ERASE);
        prog   = in_idle && r_q.arm_dr && (ir == OP_PROG);
        verify = in_idle && r_q.arm_dr && (ir == OP_VERIFY);

        r_d        = r_q;
        r_d.arm_ir = (state == IR_UPDATE);
        r_d.arm_dr = (state == DR_UPDATE);

        if (state == TAP_RESET) begin
            r_d.en = 1'b0;
        end else if (ir == OP_ENABLE) begin
            r_d.en = 1'b1;
        end

        if (sel_isp && state == DR_SHIFT) begin
            r_d.sr = {tdi, r_q.sr[SW-1:1]};
        end
        if (verify) begin
            r_d.sr[DW-1:0] = row_rdata;
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sr_so = r_q.sr[0];
    assign en    = r_q.en;
    assign row   = r_q.sr[SW-1:DW];
    assign wdata = r_q.sr[DW-1:0];

endmodule

// File: rtl/isp_tap.sv
module isp_tap
    import isp_tap_pkg::*;
#(
    parameter int          ROW_AW = 4,
    parameter int          ROW_DW = 8,
    parameter logic [31:0] IDCODE = 32'h1C3A_5E2F
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              cfg_erase,
    output logic              cfg_prog,
    output logic              cfg_verify,
    output logic [ROW_AW-1:0] cfg_row,
    output logic [ROW_DW-1:0] cfg_wdata,
    input  logic [ROW_DW-1:0] cfg_rdata
);

    localparam int ID_W = 32;

    tap_state_e      st;
    logic [IR_W-1:0] ir_cur;
    logic            ir_so;
    logic            byp_so;
    logic            id_so;
    logic            isp_so;
    logic            isp_en;
    dr_sel_e         dr_sel;

    assign dr_sel = dr_select(ir_cur);

    isp_tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (st)
    );

    isp_tap_ir u_ir (
        .tck   (tck),
        .por_n (por_n),
        .state (st),
        .tdi   (tdi),
        .ir    (ir_cur),
        .ir_so (ir_so)
    );

    isp_tap_dr #(
        .ID_W   (ID_W),
        .IDCODE (IDCODE)
    ) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .state  (st),
        .sel    (dr_sel),
        .tdi    (tdi),
        .byp_so (byp_so),
        .id_so  (id_so)
    );

    isp_tap_isp #(
        .AW (ROW_AW),
        .DW (ROW_DW)
    ) u_isp (
        .tck       (tck),
        .por_n     (por_n),
        .state     (st),
        .ir        (ir_cur),
        .tdi       (tdi),
        .row_rdata (cfg_rdata),
        .sr_so     (isp_so),
        .en        (isp_en),
        .erase     (cfg_erase),
        .prog      (cfg_prog),
        .verify    (cfg_verify),
        .row       (cfg_row),
        .wdata     (cfg_wdata)
    );

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d.oe  = (st == DR_SHIFT) || (st == IR_SHIFT);
        o_d.tdo = 1'b0;
        if (st == IR_SHIFT) begin
            o_d.tdo = ir_so;
        end else if (st == DR_SHIFT) begin
            case (dr_sel)
                SEL_ID:  o_d.tdo = id_so;
                SEL_ISP: o_d.tdo = isp_so;
                default: o_d.tdo = byp_so;
            endcase
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo    = o_q.tdo;
    assign tdo_oe = o_q.oe;

endmodule

// File: rtl/isp_tap_chk.sv
module isp_tap_chk
    import isp_tap_pkg::*;
(
    input logic       tck,
    input logic       por_n,
    input logic       tms,
    input logic [3:0] state,
    input logic       en,
    input logic       tdo_oe,
    input logic       erase,
    input logic       prog,
    input logic       verify
);

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TAP_RESET && tms) |=> (state == TAP_RESET));

    // R1
    tlr_leave_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TAP_RESET && !tms) |=> (state == TAP_IDLE));

    // R6
    en_clear_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TAP_RESET) |=> !en);

    // R8
    strobe_onehot_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({erase, prog, verify}));

    // R8
    strobe_single_chk: assert property (@(posedge tck) disable iff (!por_n)
        (erase || prog || verify) |=> !(erase || prog || verify));

    // R8
    row_after_dr_chk: assert property (@(posedge tck) disable iff (!por_n)
        (prog || verify) |-> ($past(state) == DR_UPDATE));

    // R8
    erase_after_upd_chk: assert property (@(posedge tck) disable iff (!por_n)
        erase |-> ($past(state) == DR_UPDATE || $past(state) == IR_UPDATE));

    // R10
    oe_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == DR_SHIFT || state == IR_SHIFT));

endmodule

bind isp_tap isp_tap_chk u_chk (
    .tck    (tck),
    .por_n  (por_n),
    .tms    (tms),
    .state  (st),
    .en     (isp_en),
    .tdo_oe (tdo_oe),
    .erase  (cfg_erase),
    .prog   (cfg_prog),
    .verify (cfg_verify)
);

// File: tb/isp_tap_test.sv
module isp_tap_test;

    localparam logic [31:0] ID_EXP = 32'h1C3A_5E2F;

    logic       tck = 1'b0;
    logic       por_n;
    logic       tms;
    logic       tdi;
    logic       tdo;
    logic       tdo_oe;
    logic       cfg_erase;
    logic       cfg_prog;
    logic       cfg_verify;
    logic [3:0] cfg_row;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;

    logic [7:0] mem [16];
    assign cfg_rdata = mem[cfg_row];

    int checks = 0;
    int errors = 0;
    int n_erase = 0;
    int n_prog = 0;
    int n_verify = 0;
    int oe_bad = 0;
    int edge_bad = 0;
    logic last_tdo;
    logic last_oe;

    always #5 tck = ~tck;

    isp_tap #(
        .ROW_AW (4),
        .ROW_DW (8),
        .IDCODE (ID_EXP)
    ) uut (
        .tck        (tck),
        .por_n      (por_n),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .cfg_erase  (cfg_erase),
        .cfg_prog   (cfg_prog),
        .cfg_verify (cfg_verify),
        .cfg_row    (cfg_row),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata)
    );

    // configuration memory model, acting mid-cycle on strobes
    always @(negedge tck) begin
        if (cfg_erase) begin
            n_erase++;
            for (int k = 0; k < 16; k++) mem[k] = 8'h00;
        end
        if (cfg_prog) begin
            n_prog++;
            mem[cfg_row] = cfg_wdata;
        end
        if (cfg_verify) n_verify++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic tms_v, input logic tdi_v);
        @(negedge tck);
        tms = tms_v;
        tdi = tdi_v;
        #1;
        last_tdo = tdo;
        last_oe  = tdo_oe;
        @(posedge tck);
        #1;
        if (last_oe && (tdo !== last_tdo)) edge_bad++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0);
            if (last_oe) oe_bad++;
        end
    endtask

    task automatic shift_ir(input logic [3:0] v, output logic [3:0] o);
        o = '0;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, v[i]);
            o[i] = last_tdo;
            if (!last_oe) oe_bad++;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic shift_dr(input logic [31:0] v, input int n, output logic [31:0] o);
        o = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, v[i]);
            o[i] = last_tdo;
            if (!last_oe) oe_bad++;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic t_reset;
        por_n = 1'b0;
        tms   = 1'b1;
        tdi   = 1'b0;
        repeat (3) @(negedge tck);
        #1;
        check("R10 oe low in reset", {31'd0, tdo_oe}, 32'd0);
        check("R7 no strobe in reset", {29'd0, cfg_erase, cfg_prog, cfg_verify}, 32'd0);
        por_n = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic t_idcode;
        logic [31:0] o;
        shift_dr(32'h0, 32, o);
        check("R2 R3 id after reset", o, ID_EXP);
    endtask

    task automatic t_bypass;
        logic [3:0]  oi;
        logic [31:0] o;
        shift_ir(4'b1111, oi);
        check("R2 ir capture", {28'd0, oi}, 32'd1);
        shift_dr(32'h0000_00B2, 8, o);
        check("R4 bypass 1111", o, {24'd0, 8'hB2 << 1});
        shift_ir(4'b0101, oi);
        shift_dr(32'h0000_004D, 8, o);
        check("R4 bypass undefined", o, {24'd0, 8'h9A});
        idle(2);
        check("R10 oe only in shift", oe_bad, 0);
    endtask

    task automatic t_no_enable;
        logic [3:0]  oi;
        logic [31:0] o;
        shift_ir(4'b1011, oi);
        shift_dr({20'd0, 4'd2, 8'h5A}, 12, o);
        idle(3);
        check("R7 prog without enable", n_prog, 0);
        check("R7 memory untouched", {24'd0, mem[2]}, 32'h77);
        shift_ir(4'b1010, oi);
        idle(3);
        check("R7 erase without enable", n_erase, 0);
    endtask

    task automatic t_program;
        logic [3:0]  oi;
        logic [31:0] o;
        shift_ir(4'b1001, oi);
        idle(2);
        shift_ir(4'b1011, oi);
        idle(2);
        check("R8 no prog on update-ir", n_prog, 0);
        shift_dr({20'd0, 4'd3, 8'hA5}, 12, o);
        idle(4);
        check("R8 prog strobe once", n_prog, 1);
        check("R5 R8 row 3 written", {24'd0, mem[3]}, 32'hA5);
        shift_dr({20'd0, 4'd7, 8'h3C}, 12, o);
        idle(2);
        check("R5 R8 row 7 written", {24'd0, mem[7]}, 32'h3C);
        check("R8 other row untouched", {24'd0, mem[2]}, 32'h77);
    endtask

    task automatic t_verify;
        logic [3:0]  oi;
        logic [31:0] o;
        int          v0;
        shift_ir(4'b1100, oi);
        idle(1);
        v0 = n_verify;
        shift_dr({20'd0, 4'd3, 8'h00}, 12, o);
        idle(3);
        check("R8 verify strobe once", n_verify - v0, 1);
        shift_dr({20'd0, 4'd3, 8'h00}, 12, o);
        check("R9 verify readback", o, {20'd0, 4'd3, 8'hA5});
        idle(1);
    endtask

    task automatic t_erase;
        logic [3:0]  oi;
        logic [31:0] o;
        shift_ir(4'b1010, oi);
        idle(3);
        check("R8 erase strobe once", n_erase, 1);
        shift_ir(4'b1100, oi);
        shift_dr({20'd0, 4'd7, 8'hFF}, 12, o);
        idle(1);
        shift_dr({20'd0, 4'd7, 8'h00}, 12, o);
        check("R9 erased row reads zero", o, {20'd0, 4'd7, 8'h00});
        idle(1);
    endtask

    task automatic t_tms_reset;
        logic [3:0]  oi;
        logic [31:0] o;
        int          p0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        shift_dr(32'h0, 32, o);
        check("R1 R2 id after tms reset", o, ID_EXP);
        p0 = n_prog;
        shift_ir(4'b1011, oi);
        shift_dr({20'd0, 4'd5, 8'hEE}, 12, o);
        idle(3);
        check("R6 enable cleared by reset", n_prog - p0, 0);
        check("R6 row 5 untouched", {24'd0, mem[5]}, 32'h00);
        check("R10 tdo stable at rising edge", edge_bad, 0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = 8'h77;
        t_reset();
        t_idcode();
        t_bypass();
        t_no_enable();
        t_program();
        t_verify();
        t_erase();
        t_tms_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule